// File: doc/BRIEF.md
# Channel Interrupt Aggregation Controller

This block gathers event pulses from two functional groups of one line channel, an alarm/error group and a framing group. Each event is captured in a sticky per-source status bit. It then passes through three gates before it can reach the channel's single interrupt request line: a per-source enable, a per-group enable and a channel master enable. Software finds the group that needs service by reading a summary register, reads that group's status, and clears what it has handled.

Two behaviours can be chosen at run time. Status bits clear either when software writes a one to them or when software reads their register. Independently, an auto-clear mode retires each set status bit a fixed number of cycles after it was set, without any software action. Access goes through a small synchronous register port. Read data is combinational from the address, and a read or write takes effect at the clock edge that ends the access cycle.

Top module: `irq_chan_aggr`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Bit 0 of the control register (address 0) is the channel master enable; while it is 0, `irq` stays low whatever the status and other enables are.
- R3: In the group enable register (address 1), bit 1 enables the alarm group and bit 0 the framing group; a group whose bit is 0 never drives `irq` and does not show in the summary register.
- R4: A set status bit contributes only when its own bit in the group's source enable register (address 3 for alarm, address 5 for framing) is 1.
- R5: A status bit (address 4 for alarm, address 6 for framing, bit i for event input i) is set by a rising edge of its event input; an input held high sets it only once.
- R6: With control bit 1 at 0, writing 1 to a status bit clears it, writing 0 leaves it, and reads do not change status.
- R7: With control bit 1 at 1, reading a status register returns its contents and clears all its bits at that edge, and writes to it are ignored.
- R8: A new event edge in the same cycle as a clear by read or by write leaves the status bit set.
- R9: With control bit 2 at 1, a set status bit clears itself `AUTOCLR_CYCLES` cycles after it was last set; a new edge restarts that count.
- R10: The summary register (address 2, read only) shows in bit 1 the alarm group and in bit 0 the framing group, each the OR of status bits that are set, source-enabled and group-enabled; writes to it have no effect.
- R11: `irq` is a register output that goes high one cycle after a qualifying status bit becomes set and low one cycle after the last one clears or is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| alm_evt | input | N_ALM | Alarm/error event inputs |
| frm_evt | input | N_FRM | Framing event inputs |
| irq | output | 1 | Channel interrupt request, active high |

## Verification
An event edge presented before clock edge k shows in status and in the summary read in the cycle after k. `irq` follows one edge later, at k+1. A clear by read or write lands at the edge that ends the access, so a read returns the pre-clear value in its own cycle and the cleared value from the next. Auto-clear drops a bit exactly `AUTOCLR_CYCLES` edges after its setting edge. The bench steps a behavioural model at each rising edge from the same inputs. It compares `irq` at every falling edge, when both sides have settled, and compares read data just after the inputs are driven in each read cycle, so every result is judged in the cycle it is due.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_GRP_EN = 3'd1,
    RA_SUMMARY= 3'd2,
    RA_ALM_EN = 3'd3,
    RA_ALM_ST = 3'd4,
    RA_FRM_EN = 3'd5,
    RA_FRM_ST = 3'd6
  } reg_addr_e;

  localparam int CTL_MASTER = 0;
  localparam int CTL_RDCLR  = 1;
  localparam int CTL_AUTO   = 2;
  localparam int CTL_W      = 3;

  localparam int GRP_FRM = 0;
  localparam int GRP_ALM = 1;
  localparam int GRP_W   = 2;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_aggr_pkg::*;
#(
  parameter int N_ALM  = 4,
  parameter int N_FRM  = 4,
  parameter int DATA_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic [GRP_W-1:0]  grp_en_o,
  output logic [N_ALM-1:0]  alm_en_o,
  output logic [N_FRM-1:0]  frm_en_o
);

  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [N_ALM-1:0] alm_q, alm_d;
  logic [N_FRM-1:0] frm_q, frm_d;

  always_comb begin
    ctrl_d = ctrl_q;
    grp_d  = grp_q;
    alm_d  = alm_q;
    frm_d  = frm_q;
    if (wr_stb_i) begin
      if (addr_i == ADDR_W'(RA_CTRL))   ctrl_d = wdata_i[CTL_W-1:0];
      if (addr_i == ADDR_W'(RA_GRP_EN)) grp_d  = wdata_i[GRP_W-1:0];
      if (addr_i == ADDR_W'(RA_ALM_EN)) alm_d  = wdata_i[N_ALM-1:0];
      if (addr_i == ADDR_W'(RA_FRM_EN)) frm_d  = wdata_i[N_FRM-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      grp_q  <= '0;
      alm_q  <= '0;
      frm_q  <= '0;
    end else if (wr_stb_i) begin
      ctrl_q <= ctrl_d;
      grp_q  <= grp_d;
      alm_q  <= alm_d;
      frm_q  <= frm_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign grp_en_o = grp_q;
  assign alm_en_o = alm_q;
  assign frm_en_o = frm_q;

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC          = 4,
  parameter int AUTOCLR_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             auto_en_i,
  output logic [N_SRC-1:0] status_o
);

  localparam int CNT_W = (AUTOCLR_CYCLES > 1) ? $clog2(AUTOCLR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AUTOCLR_CYCLES - 1);

  logic [N_SRC-1:0] evt_q;
  logic [N_SRC-1:0] set_v;
  logic [N_SRC-1:0] expire_v;
  logic [N_SRC-1:0] status_q, status_d;

  assign set_v = evt_i & ~evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_i;
  end

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    assign expire_v[b] = auto_en_i && status_q[b] && (cnt_q == CNT_LAST);
    assign cnt_en      = set_v[b] || status_q[b] || (cnt_q != '0);

    always_comb begin
      if (set_v[b] || !status_q[b] || !auto_en_i) cnt_d = '0;
      else                                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    // R9: an expiring bit with no fresh edge is gone at the next edge
    assert_autoclr_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && status_q[b] && (cnt_q == CNT_LAST) && !set_v[b]) |=> !status_q[b]);
  end

  assign status_d = (status_q & ~clr_i & ~expire_v) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // R8: an input edge always leaves its bit set, whatever clear is applied
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & ~evt_q)) |=> ((status_q & $past(evt_i & ~evt_q)) == $past(evt_i & ~evt_q)));

  // R5: a bit never rises without an input edge in the cycle before
  assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i & ~evt_q)) == '0));

endmodule

// File: rtl/irq_chan_aggr.sv
module irq_chan_aggr
  import irq_aggr_pkg::*;
#(
  parameter int N_ALM          = 4,
  parameter int N_FRM          = 4,
  parameter int DATA_W         = 4,
  parameter int ADDR_W         = 3,
  parameter int AUTOCLR_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_ALM-1:0]  alm_evt,
  input  logic [N_FRM-1:0]  frm_evt,
  output logic              irq
);

  logic             wr_stb, rd_stb;
  logic [CTL_W-1:0] ctrl;
  logic [GRP_W-1:0] grp_en;
  logic [N_ALM-1:0] alm_en, alm_st, alm_clr;
  logic [N_FRM-1:0] frm_en, frm_st, frm_clr;
  logic [GRP_W-1:0] grp_pend;
  logic             irq_d, irq_q;

  assign wr_stb = bus_sel &&  bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  irq_cfg_regs #(
    .N_ALM(N_ALM), .N_FRM(N_FRM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .ctrl_o(ctrl), .grp_en_o(grp_en),
    .alm_en_o(alm_en), .frm_en_o(frm_en)
  );

  always_comb begin
    if (ctrl[CTL_RDCLR]) begin
      alm_clr = {N_ALM{rd_stb && (bus_addr == ADDR_W'(RA_ALM_ST))}};
      frm_clr = {N_FRM{rd_stb && (bus_addr == ADDR_W'(RA_FRM_ST))}};
    end else begin
      alm_clr = {N_ALM{wr_stb && (bus_addr == ADDR_W'(RA_ALM_ST))}} & bus_wdata[N_ALM-1:0];
      frm_clr = {N_FRM{wr_stb && (bus_addr == ADDR_W'(RA_FRM_ST))}} & bus_wdata[N_FRM-1:0];
    end
  end

  irq_src_bank #(.N_SRC(N_ALM), .AUTOCLR_CYCLES(AUTOCLR_CYCLES)) u_alm (
    .clk(clk), .rst_n(rst_n), .evt_i(alm_evt), .clr_i(alm_clr),
    .auto_en_i(ctrl[CTL_AUTO]), .status_o(alm_st)
  );

  irq_src_bank #(.N_SRC(N_FRM), .AUTOCLR_CYCLES(AUTOCLR_CYCLES)) u_frm (
    .clk(clk), .rst_n(rst_n), .evt_i(frm_evt), .clr_i(frm_clr),
    .auto_en_i(ctrl[CTL_AUTO]), .status_o(frm_st)
  );

  assign grp_pend[GRP_ALM] = grp_en[GRP_ALM] && |(alm_st & alm_en);
  assign grp_pend[GRP_FRM] = grp_en[GRP_FRM] && |(frm_st & frm_en);
  assign irq_d = ctrl[CTL_MASTER] && |grp_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(RA_CTRL):    bus_rdata[CTL_W-1:0] = ctrl;
      ADDR_W'(RA_GRP_EN):  bus_rdata[GRP_W-1:0] = grp_en;
      ADDR_W'(RA_SUMMARY): bus_rdata[GRP_W-1:0] = grp_pend;
      ADDR_W'(RA_ALM_EN):  bus_rdata[N_ALM-1:0] = alm_en;
      ADDR_W'(RA_ALM_ST):  bus_rdata[N_ALM-1:0] = alm_st;
      ADDR_W'(RA_FRM_EN):  bus_rdata[N_FRM-1:0] = frm_en;
      ADDR_W'(RA_FRM_ST):  bus_rdata[N_FRM-1:0] = frm_st;
      default:             bus_rdata = '0;
    endcase
  end

  // R2: master enable off means no request on the following cycle
  assert_master_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CTL_MASTER] |=> !irq);

  // R3: both groups disabled means no request on the following cycle
  assert_group_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en == '0) |=> !irq);

  // R4: no source enabled anywhere means no request on the following cycle
  assert_source_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((alm_en == '0) && (frm_en == '0)) |=> !irq);

  // R10: a group shown pending must have a set status bit behind it
  assert_summary_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_pend[GRP_ALM] |-> (alm_st != '0)) and (grp_pend[GRP_FRM] |-> (frm_st != '0)));

endmodule

// File: tb/irq_chan_aggr_test.sv
module irq_chan_aggr_test;

  localparam int NA = 4;
  localparam int NF = 4;
  localparam int DW = 4;
  localparam int AW = 3;
  localparam int AC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [NA-1:0] alm_evt, alm_nx;
  logic [NF-1:0] frm_evt, frm_nx;
  logic          irq;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  irq_chan_aggr #(.N_ALM(NA), .N_FRM(NF), .DATA_W(DW), .ADDR_W(AW), .AUTOCLR_CYCLES(AC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alm_evt(alm_evt), .frm_evt(frm_evt), .irq(irq)
  );

  // behavioural reference
  logic [2:0]    m_ctrl;
  logic [1:0]    m_grp;
  logic [NA-1:0] m_aen, m_ast, m_aprev;
  logic [NF-1:0] m_fen, m_fst, m_fprev;
  int            m_acnt [NA];
  int            m_fcnt [NF];
  logic          m_irq;

  function automatic logic [1:0] m_summary();
    m_summary = {m_grp[1] && ((m_ast & m_aen) != 0), m_grp[0] && ((m_fst & m_fen) != 0)};
  endfunction

  function automatic logic [DW-1:0] m_read(input int a);
    case (a)
      0: m_read = DW'(m_ctrl);
      1: m_read = DW'(m_grp);
      2: m_read = DW'(m_summary());
      3: m_read = m_aen;
      4: m_read = m_ast;
      5: m_read = m_fen;
      6: m_read = m_fst;
      default: m_read = '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_grp = '0; m_aen = '0; m_fen = '0; m_ast = '0; m_fst = '0;
      m_aprev = '0; m_fprev = '0; m_irq = 1'b0;
      for (int i = 0; i < NA; i++) m_acnt[i] = 0;
      for (int i = 0; i < NF; i++) m_fcnt[i] = 0;
    end else begin
      logic [NA-1:0] arise, aclr;
      logic [NF-1:0] frise, fclr;
      logic [NA-1:0] ast_n;
      logic [NF-1:0] fst_n;
      bit rd, wr;
      rd = bus_sel && !bus_wr;
      wr = bus_sel && bus_wr;
      arise = alm_evt & ~m_aprev;
      frise = frm_evt & ~m_fprev;
      aclr = '0; fclr = '0;
      if (m_ctrl[1]) begin
        if (rd && bus_addr == 4) aclr = '1;
        if (rd && bus_addr == 6) fclr = '1;
      end else begin
        if (wr && bus_addr == 4) aclr = bus_wdata;
        if (wr && bus_addr == 6) fclr = bus_wdata;
      end
      ast_n = m_ast; fst_n = m_fst;
      for (int i = 0; i < NA; i++) begin
        if (aclr[i] || (m_ctrl[2] && m_ast[i] && m_acnt[i] == AC - 1)) ast_n[i] = 1'b0;
        if (arise[i]) ast_n[i] = 1'b1;
        m_acnt[i] = (arise[i] || !m_ast[i] || !m_ctrl[2]) ? 0 : m_acnt[i] + 1;
      end
      for (int i = 0; i < NF; i++) begin
        if (fclr[i] || (m_ctrl[2] && m_fst[i] && m_fcnt[i] == AC - 1)) fst_n[i] = 1'b0;
        if (frise[i]) fst_n[i] = 1'b1;
        m_fcnt[i] = (frise[i] || !m_fst[i] || !m_ctrl[2]) ? 0 : m_fcnt[i] + 1;
      end
      m_irq = m_ctrl[0] && (m_summary() != 0);
      if (wr) begin
        if (bus_addr == 0) m_ctrl = bus_wdata[2:0];
        if (bus_addr == 1) m_grp  = bus_wdata[1:0];
        if (bus_addr == 3) m_aen  = bus_wdata;
        if (bus_addr == 5) m_fen  = bus_wdata;
      end
      m_ast = ast_n; m_fst = fst_n;
      m_aprev = alm_evt; m_fprev = frm_evt;
    end
  end

  task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // one bus cycle: compare irq at the falling edge, drive, compare read data
  task automatic cyc(input bit s, input bit w, input int a, input int d);
    @(negedge clk);
    check("irq", DW'(irq), DW'(m_irq));
    bus_sel = s; bus_wr = w; bus_addr = AW'(a); bus_wdata = DW'(d);
    alm_evt = alm_nx; frm_evt = frm_nx;
    #1;
    if (s && !w) check($sformatf("rdata@%0d", a), bus_rdata, m_read(a));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
  endtask
  task automatic wr(input int a, input int d); cyc(1, 1, a, d); endtask
  task automatic rd(input int a);              cyc(1, 0, a, 0); endtask

  // checks against a literal value the bench derived by hand
  task automatic rd_expect(input int a, input int v);
    cyc(1, 0, a, 0);
    check($sformatf("lit@%0d", a), bus_rdata, DW'(v));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    alm_evt = '0; frm_evt = '0; alm_nx = '0; frm_nx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    for (int a = 0; a < 7; a++) rd_expect(a, 0);
    check("irq reset", DW'(irq), '0);

    // enable sweep over master, both groups and source enables
    for (int c = 0; c < 16; c++) begin
      bit ch, ga, gf, se;
      ch = c[0]; ga = c[1]; gf = c[2]; se = c[3];
      if (!ch)           cur_req = "R2";
      else if (!ga && !gf) cur_req = "R3";
      else if (!se)      cur_req = "R4";
      else               cur_req = "R11";
      wr(0, int'(ch));
      wr(1, {ga, gf});
      wr(3, se ? 4'b0101 : 4'b0000);
      wr(5, se ? 4'b0010 : 4'b0000);
      alm_nx = 4'b0001; frm_nx = 4'b0010;
      idle(1);
      alm_nx = '0; frm_nx = '0;
      idle(3);
      cur_req = "R10";
      rd(2);
      rd_expect(2, {ga && se, gf && se});
      wr(2, 4'hF);
      rd(2);
      cur_req = "R5";
      rd_expect(4, 4'b0001);
      rd_expect(6, 4'b0010);
      cur_req = "R6";
      wr(4, 4'hF); wr(6, 4'hF);
      idle(2);
      rd_expect(4, 0);
    end

    // write-one-to-clear with partial masks
    cur_req = "R6";
    wr(0, 1); wr(1, 3); wr(3, 4'hF); wr(5, 4'hF);
    alm_nx = 4'b0111; idle(1); alm_nx = '0; idle(2);
    wr(4, 4'b0010);
    rd_expect(4, 4'b0101);
    rd_expect(4, 4'b0101);
    wr(4, 0);
    rd_expect(4, 4'b0101);
    wr(4, 4'hF);
    idle(2);

    // a held level sets once
    cur_req = "R5";
    alm_nx = 4'b1000; idle(2);
    rd_expect(4, 4'b1000);
    wr(4, 4'hF);
    idle(4);
    rd_expect(4, 0);
    alm_nx = '0; idle(2);

    // clear on read
    cur_req = "R7";
    wr(0, 3);
    frm_nx = 4'b0001; idle(1); frm_nx = '0; idle(2);
    wr(6, 4'hF);
    rd_expect(6, 4'b0001);
    rd_expect(6, 0);
    idle(2);

    // edge in the same cycle as a clear
    cur_req = "R8";
    alm_nx = 4'b0001; idle(1); alm_nx = '0; idle(1);
    alm_nx = 4'b0010; rd(4); alm_nx = '0;
    rd_expect(4, 4'b0010);
    rd(4);
    wr(0, 1);
    frm_nx = 4'b0100; idle(1); frm_nx = '0; idle(1);
    frm_nx = 4'b1000; wr(6, 4'hF); frm_nx = '0;
    rd_expect(6, 4'b1000);
    wr(6, 4'hF);
    idle(2);

    // auto-clear, plus a retrigger that restarts the count
    cur_req = "R9";
    wr(0, 5);
    alm_nx = 4'b0001; idle(1); alm_nx = '0;
    idle(AC - 2);
    rd_expect(4, 4'b0001);
    idle(1);
    rd_expect(4, 0);
    frm_nx = 4'b0001; idle(1); frm_nx = '0;
    idle(AC / 2);
    frm_nx = 4'b0001; idle(1); frm_nx = '0;
    idle(AC - 2);
    rd_expect(6, 4'b0001);
    idle(AC + 2);
    rd_expect(6, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule